// File: doc/BRIEF.md
# ATA Device Status and Interrupt Controller

This block owns the device-side status byte of a parallel ATA task-file interface and drives the interrupt request line towards the host. It watches host register accesses on the 3-bit command-block address, a hardware reset, the soft-reset bit of the device control register and a set of pulses and levels from the device's command engine. From these it keeps the busy/data-request state, the condition bits and the pending interrupt. It also steers the read data path: while the device is busy, every command-block read returns the status byte.

A small state machine drives the busy and data-request indications. Its four states are `ST_RESET` (busy after a reset), `ST_IDLE` (ready for a command), `ST_CMD` (busy executing) and `ST_DRQ` (waiting for the host to move a data block). The transitions are: any state to `ST_RESET` on a soft-reset rising edge or hardware reset. `ST_RESET` to `ST_IDLE` on reset completion or on timeout. `ST_IDLE` to `ST_CMD` on a command write. `ST_CMD` to `ST_DRQ` on a data request. `ST_DRQ` to `ST_CMD` on block completion. `ST_CMD` or `ST_DRQ` to `ST_IDLE` on command completion.

Top module: `ata_stat_irq`

## Requirements
- R1: The status byte is {BSY, DRDY, DF, DSC, DRQ, CORR, 0, ERR} from bit 7 down to bit 0, and bit 1 always reads 0. While the hardware reset `rst_n` is low, the status byte is 0x80 and `intrq_o` is 0.
- R2: A host write to address 7 (the command address) while idle sets BSY from the next cycle. A write to address 7 during `ST_CMD`, `ST_DRQ` or `ST_RESET` changes nothing.
- R3: A completion pulse in `ST_CMD` or `ST_DRQ` clears BSY and DRQ on the next cycle, captures `err_i`, `corr_i`, `df_i` and `dsc_i` into ERR, CORR, DF and DSC, and raises `intrq_o`. A completion pulse while idle is ignored.
- R4: A data-request pulse in `ST_CMD` sets DRQ, clears BSY and raises `intrq_o`. A block-done pulse in `ST_DRQ` returns the block to BSY=1 with DRQ=0. BSY and DRQ are never 1 together.
- R5: While BSY is 1, `host_rdata` equals the status byte for every address. While BSY is 0, address 7 returns the status byte and the other addresses return `reg_rdata_i`.
- R6: A host read of address 7 clears `intrq_o` on the next cycle. Reads of other addresses leave it pending. A completion or data-request event in the same cycle as the read wins, and the interrupt stays set.
- R7: Releasing `rst_n`, or a rising edge of `srst_i`, gives BSY=1. Holding `srst_i` high does not restart the reset. `rst_done_i` ends the reset state. A soft reset clears ERR, CORR, DF, DSC and the pending interrupt.
- R8: BSY stays set in the reset state for at most `TMO_CYC` cycles. On expiry BSY clears and DF is set.
- R9: DRDY is 0 after hardware reset and whenever `spin_rdy_i` is low. It is set on a rising edge of `spin_rdy_i`, or when a reset completes while `spin_rdy_i` is high. A `ev_notrdy_i` pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, active low |
| host_addr | input | 3 | Command-block register address |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| reg_rdata_i | input | 8 | Read data of the other task-file registers |
| host_rdata | output | 8 | Read data returned to the host |
| srst_i | input | 1 | Soft-reset bit of the device control register |
| rst_done_i | input | 1 | Pulse: the device reset process has finished |
| ev_drq_i | input | 1 | Pulse: device requests a data block |
| ev_blk_i | input | 1 | Pulse: the current data block has been moved |
| ev_done_i | input | 1 | Pulse: command complete |
| ev_notrdy_i | input | 1 | Pulse: not-ready found when the command was received |
| err_i | input | 1 | Error result, sampled at completion |
| corr_i | input | 1 | Corrected-data result, sampled at completion |
| df_i | input | 1 | Device-fault result, sampled at completion |
| dsc_i | input | 1 | Seek-complete result, sampled at completion |
| spin_rdy_i | input | 1 | Spindle at steady speed |
| status_o | output | 8 | Status byte |
| intrq_o | output | 1 | Interrupt request to the host |

## Verification
Four properties are checked on every cycle: BSY and DRQ never show together, the busy read redirect holds, a command write while idle is followed by BSY, and completion or a status-read acknowledge takes effect on the next cycle. The reset dwell time is tracked by an independent counter against the timeout bound. Other behaviours need the bench's scenarios. These are the captured condition bits and their persistence, the DRDY rules around the spindle and the not-ready pulse, soft reset that is held rather than pulsed, completion pulses ignored while idle, and the same-cycle race between an interrupt set and its acknowledge.

// File: rtl/ata_stat_pkg.sv
package ata_stat_pkg;

    localparam logic [2:0] ADDR_CMD  = 3'd7;  // write: command
    localparam logic [2:0] ADDR_STAT = 3'd7;  // read: status

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_IDLE  = 2'd1,
        ST_CMD   = 2'd2,
        ST_DRQ   = 2'd3
    } ata_st_e;

    typedef struct packed {
        logic bsy;
        logic drdy;
        logic df;
        logic dsc;
        logic drq;
        logic corr;
        logic zero;
        logic err;
    } stat_byte_t;

endpackage

// File: rtl/ata_busy_fsm.sv
module ata_busy_fsm
    import ata_stat_pkg::*;
#(
    parameter int unsigned TMO_CYC = 1_500_000_000
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    srst_rise,
    input  logic    cmd_wr,
    input  logic    ev_drq,
    input  logic    ev_blk,
    input  logic    ev_done,
    input  logic    rst_done,
    output ata_st_e state,
    output logic    done_acc,
    output logic    drq_acc,
    output logic    rdy_acc,
    output logic    tmo_hit
);
    localparam int unsigned CNT_W = $clog2(TMO_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_CYC - 1);

    ata_st_e          st_n;
    logic [CNT_W-1:0] cnt;
    logic             cnt_last;

    assign cnt_last = (cnt == CNT_LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RESET;
        else        state <= st_n;
    end

    // reset dwell counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                 cnt <= '0;
        else if (srst_rise || state != ST_RESET)    cnt <= '0;
        else                                        cnt <= cnt + 1'b1;
    end

    // next state
    always_comb begin
        st_n = state;
        if (srst_rise) begin
            st_n = ST_RESET;
        end else begin
            unique case (state)
                ST_RESET: if (rst_done || cnt_last) st_n = ST_IDLE;
                ST_IDLE:  if (cmd_wr)               st_n = ST_CMD;
                ST_CMD: begin
                    if (ev_done)     st_n = ST_IDLE;
                    else if (ev_drq) st_n = ST_DRQ;
                end
                ST_DRQ: begin
                    if (ev_done)     st_n = ST_IDLE;
                    else if (ev_blk) st_n = ST_CMD;
                end
            endcase
        end
    end

    // accepted-event outputs
    always_comb begin
        done_acc = 1'b0;
        drq_acc  = 1'b0;
        rdy_acc  = 1'b0;
        tmo_hit  = 1'b0;
        if (!srst_rise) begin
            unique case (state)
                ST_RESET: begin
                    rdy_acc = rst_done;
                    tmo_hit = !rst_done && cnt_last;
                end
                ST_IDLE: ;
                ST_CMD: begin
                    done_acc = ev_done;
                    drq_acc  = ev_drq && !ev_done;
                end
                ST_DRQ: done_acc = ev_done;
            endcase
        end
    end

endmodule

// File: rtl/ata_stat_bits.sv
module ata_stat_bits (
    input  logic clk,
    input  logic rst_n,
    input  logic srst_rise,
    input  logic done_acc,
    input  logic tmo_hit,
    input  logic rdy_acc,
    input  logic ev_notrdy,
    input  logic spin_rdy,
    input  logic err_in,
    input  logic corr_in,
    input  logic df_in,
    input  logic dsc_in,
    output logic drdy,
    output logic df,
    output logic dsc,
    output logic corr,
    output logic err
);
    logic spin_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spin_q <= 1'b0;
            drdy   <= 1'b0;
        end else begin
            spin_q <= spin_rdy;
            if (!spin_rdy || ev_notrdy)           drdy <= 1'b0;
            else if (!spin_q || rdy_acc)          drdy <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            df   <= 1'b0;
            dsc  <= 1'b0;
            corr <= 1'b0;
            err  <= 1'b0;
        end else if (srst_rise) begin
            df   <= 1'b0;
            dsc  <= 1'b0;
            corr <= 1'b0;
            err  <= 1'b0;
        end else if (done_acc) begin
            df   <= df_in;
            dsc  <= dsc_in;
            corr <= corr_in;
            err  <= err_in;
        end else if (tmo_hit) begin
            df   <= 1'b1;
        end
    end

endmodule

// File: rtl/ata_irq_ctl.sv
module ata_irq_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic srst_rise,
    input  logic set_ev,
    input  logic ack,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         irq <= 1'b0;
        else if (srst_rise) irq <= 1'b0;
        else if (set_ev)    irq <= 1'b1;
        else if (ack)       irq <= 1'b0;
    end
endmodule

// File: rtl/ata_stat_irq.sv
module ata_stat_irq
    import ata_stat_pkg::*;
#(
    parameter int unsigned TMO_CYC = 1_500_000_000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] host_addr,
    input  logic       host_rd,
    input  logic       host_wr,
    input  logic [7:0] reg_rdata_i,
    output logic [7:0] host_rdata,
    input  logic       srst_i,
    input  logic       rst_done_i,
    input  logic       ev_drq_i,
    input  logic       ev_blk_i,
    input  logic       ev_done_i,
    input  logic       ev_notrdy_i,
    input  logic       err_i,
    input  logic       corr_i,
    input  logic       df_i,
    input  logic       dsc_i,
    input  logic       spin_rdy_i,
    output logic [7:0] status_o,
    output logic       intrq_o
);
    ata_st_e    fsm_state;
    stat_byte_t sb;
    logic       srst_q, srst_rise;
    logic       cmd_wr, stat_rd;
    logic       done_acc, drq_acc, rdy_acc, tmo_hit;
    logic       drdy, df, dsc, corr, err;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) srst_q <= 1'b0;
        else        srst_q <= srst_i;
    end

    assign srst_rise = srst_i && !srst_q;
    assign cmd_wr    = host_wr && (host_addr == ADDR_CMD);
    assign stat_rd   = host_rd && (host_addr == ADDR_STAT);

    ata_busy_fsm #(.TMO_CYC(TMO_CYC)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_rise (srst_rise),
        .cmd_wr    (cmd_wr),
        .ev_drq    (ev_drq_i),
        .ev_blk    (ev_blk_i),
        .ev_done   (ev_done_i),
        .rst_done  (rst_done_i),
        .state     (fsm_state),
        .done_acc  (done_acc),
        .drq_acc   (drq_acc),
        .rdy_acc   (rdy_acc),
        .tmo_hit   (tmo_hit)
    );

    ata_stat_bits u_bits (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_rise (srst_rise),
        .done_acc  (done_acc),
        .tmo_hit   (tmo_hit),
        .rdy_acc   (rdy_acc),
        .ev_notrdy (ev_notrdy_i),
        .spin_rdy  (spin_rdy_i),
        .err_in    (err_i),
        .corr_in   (corr_i),
        .df_in     (df_i),
        .dsc_in    (dsc_i),
        .drdy      (drdy),
        .df        (df),
        .dsc       (dsc),
        .corr      (corr),
        .err       (err)
    );

    ata_irq_ctl u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst_rise (srst_rise),
        .set_ev    (done_acc || drq_acc),
        .ack       (stat_rd),
        .irq       (intrq_o)
    );

    always_comb begin
        sb.bsy  = (fsm_state == ST_RESET) || (fsm_state == ST_CMD);
        sb.drdy = drdy;
        sb.df   = df;
        sb.dsc  = dsc;
        sb.drq  = (fsm_state == ST_DRQ);
        sb.corr = corr;
        sb.zero = 1'b0;
        sb.err  = err;
    end

    assign status_o   = sb;
    assign host_rdata = (sb.bsy || host_addr == ADDR_STAT) ? status_o : reg_rdata_i;

endmodule

// File: rtl/ata_stat_irq_chk.sv
module ata_stat_irq_chk
    import ata_stat_pkg::*;
#(
    parameter int unsigned TMO_CYC = 1_500_000_000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] host_addr,
    input logic       host_rd,
    input logic       host_wr,
    input logic [7:0] host_rdata,
    input logic       ev_drq_i,
    input logic       ev_done_i,
    input logic       srst_rise,
    input ata_st_e    st,
    input logic [7:0] status_o,
    input logic       intrq_o
);
    logic [31:0] rcnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              rcnt <= '0;
        else if (st == ST_RESET && !srst_rise)   rcnt <= rcnt + 1;
        else                                     rcnt <= '0;
    end

    p_cmd_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == ADDR_CMD && st == ST_IDLE) |=> status_o[7]);

    p_done_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_done_i && !srst_rise && (st == ST_CMD || st == ST_DRQ))
        |=> (intrq_o && !status_o[7] && !status_o[3]));

    p_bsy_drq_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_o[7] && status_o[3]));

    p_busy_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[7] |-> (host_rdata == status_o));

    p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == ADDR_STAT && !ev_done_i && !ev_drq_i) |=> !intrq_o);

    p_tmo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RESET) |-> (rcnt < TMO_CYC));

endmodule

bind ata_stat_irq ata_stat_irq_chk #(.TMO_CYC(TMO_CYC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_addr  (host_addr),
    .host_rd    (host_rd),
    .host_wr    (host_wr),
    .host_rdata (host_rdata),
    .ev_drq_i   (ev_drq_i),
    .ev_done_i  (ev_done_i),
    .srst_rise  (srst_rise),
    .st         (fsm_state),
    .status_o   (status_o),
    .intrq_o    (intrq_o)
);

// File: tb/ata_stat_irq_test.sv
module ata_stat_irq_test;
    localparam int CLK_P = 10;
    localparam int TMO   = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] reg_rdata_i = 8'h5A;
    logic [7:0] host_rdata;
    logic       srst_i = 0, rst_done_i = 0, ev_drq_i = 0, ev_blk_i = 0;
    logic       ev_done_i = 0, ev_notrdy_i = 0;
    logic       err_i = 0, corr_i = 0, df_i = 0, dsc_i = 0, spin_rdy_i = 0;
    logic [7:0] status_o;
    logic       intrq_o;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    typedef struct {
        string      req;
        bit         kind;   // 0: status+irq, 1: read data
        logic [8:0] exp;
    } sb_item_t;

    sb_item_t sbq[$];
    sb_item_t cur;
    event     sb_ev;

    always #(CLK_P/2) clk = ~clk;

    ata_stat_irq #(.TMO_CYC(TMO)) uut (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
        .host_wr(host_wr), .reg_rdata_i(reg_rdata_i), .host_rdata(host_rdata),
        .srst_i(srst_i), .rst_done_i(rst_done_i), .ev_drq_i(ev_drq_i),
        .ev_blk_i(ev_blk_i), .ev_done_i(ev_done_i), .ev_notrdy_i(ev_notrdy_i),
        .err_i(err_i), .corr_i(corr_i), .df_i(df_i), .dsc_i(dsc_i),
        .spin_rdy_i(spin_rdy_i), .status_o(status_o), .intrq_o(intrq_o)
    );

    // monitor: pops expected items and compares with the outputs
    initial begin
        forever begin
            @(sb_ev);
            while (sbq.size() > 0) begin
                cur = sbq.pop_front();
                total++;
                if (cur.kind == 1'b0) begin
                    if ({intrq_o, status_o} !== cur.exp) begin
                        bad++;
                        $display("FAIL %s: irq/status actual=%b/%h expected=%b/%h",
                                 cur.req, intrq_o, status_o, cur.exp[8], cur.exp[7:0]);
                    end
                end else if (host_rdata !== cur.exp[7:0]) begin
                    bad++;
                    $display("FAIL %s: rdata actual=%h expected=%h",
                             cur.req, host_rdata, cur.exp[7:0]);
                end
            end
        end
    end

    function automatic logic [7:0] mk(bit bsy, bit drdy, bit df, bit dsc,
                                      bit drq, bit corr, bit err);
        return {bsy, drdy, df, dsc, drq, corr, 1'b0, err};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic exp_st(string req, logic [7:0] st, logic irq);
        sb_item_t it;
        #1;
        it.req = req; it.kind = 1'b0; it.exp = {irq, st};
        sbq.push_back(it);
        -> sb_ev;
    endtask

    task automatic exp_rd(string req, logic [7:0] d);
        sb_item_t it;
        #1;
        it.req = req; it.kind = 1'b1; it.exp = {1'b0, d};
        sbq.push_back(it);
        -> sb_ev;
    endtask

    task automatic wr_cmd();
        host_addr = 3'd7; host_wr = 1'b1;
        tick();
        host_wr = 1'b0;
    endtask

    task automatic rd_stat(string req, logic [7:0] d);
        host_addr = 3'd7; host_rd = 1'b1;
        exp_rd(req, d);
        tick();
        host_rd = 1'b0;
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 20000);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        summary();
    end

    initial begin
        @(negedge clk);
        tick(); tick();
        exp_st("R1 reset state", 8'h80, 1'b0);
        rst_n = 1'b1;
        repeat (5) tick();
        exp_st("R7 busy after reset release", 8'h80, 1'b0);
        rst_done_i = 1; tick(); rst_done_i = 0;
        exp_st("R9 no drdy while spindle low", 8'h00, 1'b0);
        spin_rdy_i = 1; tick();
        exp_st("R9 drdy on spindle ready", mk(0,1,0,0,0,0,0), 1'b0);

        // simple command
        wr_cmd();
        exp_st("R2 busy after command write", 8'hC0, 1'b0);
        host_addr = 3'd3;
        exp_rd("R5 busy read redirect", 8'hC0);
        dsc_i = 1; ev_done_i = 1; tick(); ev_done_i = 0;
        exp_st("R3 completion", mk(0,1,0,1,0,0,0), 1'b1);
        host_addr = 3'd3; host_rd = 1'b1;
        exp_rd("R5 idle read of other register", 8'h5A);
        tick(); host_rd = 1'b0;
        exp_st("R6 other read keeps irq", 8'h50, 1'b1);
        rd_stat("R5 status read idle", 8'h50);
        exp_st("R6 status read acks", 8'h50, 1'b0);

        // data command
        wr_cmd();
        exp_st("R2 busy again", 8'hD0, 1'b0);
        ev_drq_i = 1; tick(); ev_drq_i = 0;
        exp_st("R4 data request", 8'h58, 1'b1);
        wr_cmd();
        exp_st("R2 command write in drq ignored", 8'h58, 1'b1);
        rd_stat("R5 status in drq", 8'h58);
        exp_st("R6 ack in drq", 8'h58, 1'b0);
        ev_blk_i = 1; tick(); ev_blk_i = 0;
        exp_st("R4 block done back to busy", 8'hD0, 1'b0);
        ev_drq_i = 1; tick(); ev_drq_i = 0;
        exp_st("R4 second data request", 8'h58, 1'b1);
        ev_blk_i = 1; tick(); ev_blk_i = 0;
        err_i = 1; corr_i = 1;
        ev_done_i = 1; tick(); ev_done_i = 0;
        exp_st("R3 completion with error and corr", mk(0,1,0,1,0,1,1), 1'b1);

        // completion while idle is ignored
        rd_stat("R5 status read", 8'h55);
        err_i = 0; corr_i = 0; dsc_i = 0;
        ev_done_i = 1; tick(); ev_done_i = 0;
        exp_st("R3 idle completion ignored", 8'h55, 1'b0);

        // set and ack in the same cycle
        dsc_i = 1;
        wr_cmd();
        exp_st("R2 busy shows stale bits", 8'hD5, 1'b0);
        ev_done_i = 1; host_addr = 3'd7; host_rd = 1'b1;
        tick(); ev_done_i = 0; host_rd = 1'b0;
        exp_st("R6 set wins over ack", 8'h50, 1'b1);

        // not-ready at command receipt
        wr_cmd();
        err_i = 1; ev_notrdy_i = 1; ev_done_i = 1;
        tick(); ev_notrdy_i = 0; ev_done_i = 0; err_i = 0;
        exp_st("R9 not-ready clears drdy", mk(0,0,0,1,0,0,1), 1'b1);
        tick();
        exp_st("R9 drdy stays low", 8'h11, 1'b1);

        // soft reset held high
        srst_i = 1; tick();
        exp_st("R7 soft reset", 8'h80, 1'b0);
        repeat (3) tick();
        exp_st("R7 held soft reset", 8'h80, 1'b0);
        srst_i = 0;
        rst_done_i = 1; tick(); rst_done_i = 0;
        exp_st("R9 drdy on reset completion", 8'h40, 1'b0);

        // timeout
        srst_i = 1; tick(); srst_i = 0;
        exp_st("R8 busy first cycle", 8'hC0, 1'b0);
        repeat (TMO - 1) tick();
        exp_st("R8 busy at last allowed cycle", 8'hC0, 1'b0);
        tick();
        exp_st("R8 timeout clears busy sets df", mk(0,1,1,0,0,0,0), 1'b0);
        spin_rdy_i = 0; tick();
        exp_st("R9 spindle low clears drdy", 8'h20, 1'b0);
        host_addr = 3'd2;
        exp_rd("R1 bit one zero in idle read", 8'h5A);

        tick();
        summary();
    end

endmodule